// File: doc/BRIEF.md
# LIN Header Auto-Baud Front End

This block sits in front of the receive UART of a LIN slave and finds the master's bit rate from each frame header. It samples the serial line on an oversampling clock. A "tick" below is one cycle of that clock. The block waits for a long dominant (low) break. It then times the sync byte that follows and reports a bit period in ticks. The receive UART uses that period to read the identifier byte and the response.

The period is taken from the span between the first and the fifth falling edge of the sync byte. That span is eight bit times no matter how the transceivers stretch or shrink the low phases. While the block times the byte, it also checks it. The falling edges must be evenly spaced, every low phase must sit inside a wide duty band, and the stop bit must stay high. If the shape is not a clean 0x55, or the result falls outside a programmed window, the block raises an abort and waits for a fresh break.

The result leaves on a valid/ready stream. The valid bit stays set, with its data frozen, until the consumer takes it with ready. While a result is waiting, new headers are not measured. The downstream header receiver treats the valid bit as the lock. It enables its identifier-byte interrupt only after a lock and never after an abort.

Top module: `lin_autobaud`

## Requirements
- R1: A break is a low level on the synchronised line lasting at least `cfg_brk_ticks` ticks and ending in a rising edge; only a break arms a measurement, and shorter lows are ignored with no lock and no abort.
- R2: The reported period equals the tick count from the first to the fifth falling edge of the sync byte, divided by 8 and truncated.
- R3: A low phase is accepted when it is between 3/8 and 5/8 of its falling-edge spacing, so sync bits from 48% to 52% duty (and further) lock to the same period as undistorted ones.
- R4: Each of the four falling-edge spacings must be within 1/8 of the first spacing; a byte other than 0x55 (sent LSB first after a low start bit) breaks this and gives an abort with no lock.
- R5: After the last low of the sync byte, the line must rise and then stay high for at least half the first spacing; a falling edge earlier gives an abort.
- R6: A computed period below `cfg_min_period` or above `cfg_max_period` gives an abort and no lock.
- R7: An abort is a one-cycle pulse on `abort_pulse`, never in the same cycle that `per_valid` rises, and the next valid break starts a new measurement.
- R8: `per_valid` stays high with `per_data` unchanged until a cycle with `per_ready` high; meanwhile breaks and sync bytes are ignored and no abort is raised.
- R9: After reset `per_valid` and `abort_pulse` are low.
- R10: The wait for the first sync edge is abandoned with an abort if the line stays high longer than `cfg_brk_ticks` ticks. A falling-edge spacing or stop low longer than 3 × `cfg_max_period` ticks also gives an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw serial line, high when idle |
| cfg_brk_ticks | input | CW | Minimum break length and delimiter timeout, in ticks |
| cfg_min_period | input | CW | Smallest acceptable bit period |
| cfg_max_period | input | CW | Largest acceptable bit period |
| per_valid | output | 1 | A measured period is on offer (lock) |
| per_ready | input | 1 | Consumer takes the period this cycle |
| per_data | output | CW | Measured bit period in ticks |
| abort_pulse | output | 1 | One-cycle pulse on a failed sync |

## Verification
The bench skews the low phases of the sync bits in both directions. It checks that the period does not move, since a design timing only the start bit would report a skewed value. A byte that differs from 0x55, a stop bit cut short, a too-slow rate and a delimiter that never ends must each abort exactly once. A design that missed any of these would hand a wrong rate to the UART. The bench also holds ready low across a second header, where a design that kept measuring would overwrite the offered period or raise a spurious abort. A break just below the threshold must pass unnoticed.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DELIM,
    ST_EDGES,
    ST_STOPRISE,
    ST_STOPHI
  } meas_st_t;

  localparam int unsigned EDGE_SPANS = 4;
endpackage

// File: rtl/lin_ab_sync.sv
module lin_ab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic lvl,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= rx_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign fall = prev & ~lvl;
  assign rise = ~prev & lvl;
endmodule

// File: rtl/lin_ab_brk.sv
module lin_ab_brk #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic          rise,
  input  logic [CW-1:0] thr,
  output logic          brk_pulse
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= rise && (low_cnt >= thr);
      if (lvl)                low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lin_ab_meas.sv
module lin_ab_meas
  import lin_ab_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          rise,
  input  logic          brk,
  input  logic          allow,
  input  logic [CW-1:0] cfg_brk,
  input  logic [CW-1:0] cfg_min,
  input  logic [CW-1:0] cfg_max,
  output logic          done,
  output logic          fail,
  output logic [CW-1:0] period
);
  localparam int EW = CW + 2;
  localparam int SW = CW + 5;

  meas_st_t      st;
  logic [EW-1:0] tcnt, low_w, iv0;
  logic [SW-1:0] sum;
  logic [2:0]    nfall;
  logic          saw_rise;

  logic [EW-1:0] lim;
  logic [SW-1:0] pw;
  logic          in_win;

  function automatic logic duty_ok(input logic [EW-1:0] lw, input logic [EW-1:0] sp);
    logic [EW+3:0] l8, s, s3, s5;
    l8 = {1'b0, lw, 3'b000};
    s  = {4'b0000, sp};
    s3 = (s << 1) + s;
    s5 = (s << 2) + s;
    return (l8 >= s3) && (l8 <= s5);
  endfunction

  function automatic logic spacing_ok(input logic [EW-1:0] iv, input logic [EW-1:0] ref0);
    logic [EW-1:0] d;
    d = (iv > ref0) ? iv - ref0 : ref0 - iv;
    return d <= (ref0 >> 3);
  endfunction

  assign lim    = ({2'b00, cfg_max} << 1) + {2'b00, cfg_max};
  assign pw     = sum >> 3;
  assign in_win = (pw >= {5'b0, cfg_min}) && (pw <= {5'b0, cfg_max});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      tcnt     <= '0;
      low_w    <= '0;
      iv0      <= '0;
      sum      <= '0;
      nfall    <= '0;
      saw_rise <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      period   <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (tcnt != '1) tcnt <= tcnt + 1'b1;
      unique case (st)
        ST_HUNT: begin
          if (brk && allow) begin
            st   <= ST_DELIM;
            tcnt <= 1;
          end
        end
        ST_DELIM: begin
          if (fall) begin
            st       <= ST_EDGES;
            tcnt     <= 1;
            nfall    <= '0;
            sum      <= '0;
            saw_rise <= 1'b0;
          end else if (tcnt > {2'b00, cfg_brk}) begin
            fail <= 1'b1;
            st   <= ST_HUNT;
          end
        end
        ST_EDGES: begin
          if (rise) begin
            low_w    <= tcnt;
            saw_rise <= 1'b1;
          end else if (fall) begin
            if (!saw_rise || !duty_ok(low_w, tcnt) ||
                (nfall != 0 && !spacing_ok(tcnt, iv0))) begin
              fail <= 1'b1;
              st   <= ST_HUNT;
            end else begin
              if (nfall == 0) iv0 <= tcnt;
              sum      <= sum + {{(SW-EW){1'b0}}, tcnt};
              nfall    <= nfall + 1'b1;
              tcnt     <= 1;
              saw_rise <= 1'b0;
              if (nfall == 3'(EDGE_SPANS - 1)) st <= ST_STOPRISE;
            end
          end else if (tcnt > lim) begin
            fail <= 1'b1;
            st   <= ST_HUNT;
          end
        end
        ST_STOPRISE: begin
          if (rise) begin
            if (duty_ok(tcnt, iv0)) begin
              st   <= ST_STOPHI;
              tcnt <= 1;
            end else begin
              fail <= 1'b1;
              st   <= ST_HUNT;
            end
          end else if (tcnt > lim) begin
            fail <= 1'b1;
            st   <= ST_HUNT;
          end
        end
        ST_STOPHI: begin
          if (fall) begin
            fail <= 1'b1;
            st   <= ST_HUNT;
          end else if (tcnt >= (iv0 >> 1)) begin
            st <= ST_HUNT;
            if (in_win) begin
              done   <= 1'b1;
              period <= pw[CW-1:0];
            end else begin
              fail <= 1'b1;
            end
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic [CW-1:0] cfg_brk_ticks,
  input  logic [CW-1:0] cfg_min_period,
  input  logic [CW-1:0] cfg_max_period,
  output logic          per_valid,
  input  logic          per_ready,
  output logic [CW-1:0] per_data,
  output logic          abort_pulse
);
  logic          lvl, fall, rise, brk, done, fail;
  logic [CW-1:0] period;

  lin_ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .lvl(lvl), .fall(fall), .rise(rise)
  );

  lin_ab_brk #(.CW(CW)) u_brk (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise),
    .thr(cfg_brk_ticks), .brk_pulse(brk)
  );

  lin_ab_meas #(.CW(CW)) u_meas (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .brk(brk),
    .allow(~per_valid), .cfg_brk(cfg_brk_ticks),
    .cfg_min(cfg_min_period), .cfg_max(cfg_max_period),
    .done(done), .fail(fail), .period(period)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_valid <= 1'b0;
      per_data  <= '0;
    end else if (done) begin
      per_valid <= 1'b1;
      per_data  <= period;
    end else if (per_valid && per_ready) begin
      per_valid <= 1'b0;
    end
  end

  assign abort_pulse = fail;
endmodule

// File: rtl/lin_ab_chk.sv
module lin_ab_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_valid,
  input logic          per_ready,
  input logic [CW-1:0] per_data,
  input logic          abort_pulse,
  input logic [CW-1:0] cfg_min_period,
  input logic [CW-1:0] cfg_max_period
);
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && !per_ready |=> per_valid && $stable(per_data)) else $error("hold"); // R8

  AST_QUIET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && !per_ready |=> !abort_pulse) else $error("quiet"); // R8

  AST_PERIOD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_valid) |-> (per_data >= cfg_min_period) && (per_data <= cfg_max_period))
    else $error("window"); // R6

  AST_ABORT_NOT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_valid) |-> !abort_pulse) else $error("abort vs lock"); // R7

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse) else $error("abort width"); // R7
endmodule

bind lin_autobaud lin_ab_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .per_valid(per_valid), .per_ready(per_ready),
  .per_data(per_data), .abort_pulse(abort_pulse),
  .cfg_min_period(cfg_min_period), .cfg_max_period(cfg_max_period)
);

// File: tb/tb_lin_autobaud.sv
module tb_lin_autobaud;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_in = 1'b1;
  logic [CW-1:0] cfg_brk_ticks = 16'd176;
  logic [CW-1:0] cfg_min_period = 16'd8;
  logic [CW-1:0] cfg_max_period = 16'd32;
  logic          per_valid, per_ready, abort_pulse;
  logic [CW-1:0] per_data;

  int total = 0, bad = 0;
  int lock_cnt = 0, abort_cnt = 0;
  logic [CW-1:0] last_data = '0;
  logic pv_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_autobaud #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .cfg_brk_ticks(cfg_brk_ticks), .cfg_min_period(cfg_min_period),
    .cfg_max_period(cfg_max_period), .per_valid(per_valid),
    .per_ready(per_ready), .per_data(per_data), .abort_pulse(abort_pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (per_valid && !pv_prev) begin
        lock_cnt++;
        last_data = per_data;
      end
      if (abort_pulse) abort_cnt++;
      pv_prev = per_valid;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  // break, delimiter, start bit and data bits; the low phases are stretched by skew
  task automatic send_frame(input int b, input int skew, input int brk,
                            input logic [7:0] data, input int stop_hi);
    logic [8:0] bits;
    int i;
    bits = {data, 1'b0};
    drive(1'b1, 2*b);
    drive(1'b0, brk);
    drive(1'b1, b);
    i = 0;
    while (i < 9) begin
      int n;
      n = 1;
      while (i + n < 9 && bits[i+n] == bits[i]) n++;
      if (bits[i]) drive(1'b1, (i + n == 9) ? n*b : n*b - skew);
      else         drive(1'b0, n*b + skew);
      i += n;
    end
    drive(1'b1, stop_hi);
    if (stop_hi < b) begin
      drive(1'b0, 3*b);
      drive(1'b1, 4*b);
    end
    drive(1'b1, 8);
  endtask

  task automatic expect_lock(input string req, input int b, input int skew, input int per);
    int l0, a0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(b, skew, 13*b, 8'h55, 4*b);
    check(lock_cnt == l0 + 1, req, lock_cnt - l0, 1);
    check(last_data == per, req, last_data, per);
    check(abort_cnt == a0, req, abort_cnt - a0, 0);
  endtask

  task automatic t_reset();
    check(per_valid == 1'b0, "R9", per_valid, 0);
    check(abort_pulse == 1'b0, "R9", abort_pulse, 0);
  endtask

  task automatic t_nominal();
    expect_lock("R2", 16, 0, 16);
    expect_lock("R2", 20, 0, 20);
  endtask

  task automatic t_skew();
    expect_lock("R3", 16, 1, 16);
    expect_lock("R3", 16, -1, 16);
    expect_lock("R3", 16, 3, 16);
  endtask

  task automatic t_bad_byte();
    int l0, a0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(16, 0, 208, 8'h54, 64);
    check(abort_cnt == a0 + 1, "R4", abort_cnt - a0, 1);
    check(lock_cnt == l0, "R4", lock_cnt - l0, 0);
  endtask

  task automatic t_short_break();
    int l0, a0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(16, 0, 128, 8'h55, 64);
    check(lock_cnt == l0 && abort_cnt == a0, "R1", (lock_cnt - l0) + (abort_cnt - a0), 0);
  endtask

  task automatic t_window();
    int l0, a0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(40, 0, 520, 8'h55, 160);
    check(abort_cnt == a0 + 1, "R6", abort_cnt - a0, 1);
    check(lock_cnt == l0 && !per_valid, "R6", lock_cnt - l0, 0);
  endtask

  task automatic t_rearm();
    expect_lock("R7", 16, 0, 16);
  endtask

  task automatic t_stop();
    int l0, a0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(16, 0, 208, 8'h55, 4);
    check(abort_cnt == a0 + 1, "R5", abort_cnt - a0, 1);
    check(lock_cnt == l0, "R5", lock_cnt - l0, 0);
  endtask

  task automatic t_timeout();
    int a0;
    a0 = abort_cnt;
    drive(1'b1, 32);
    drive(1'b0, 208);
    drive(1'b1, 400);
    check(abort_cnt == a0 + 1, "R10", abort_cnt - a0, 1);
  endtask

  task automatic t_hold();
    int l0, a0;
    per_ready = 1'b0;
    l0 = lock_cnt; a0 = abort_cnt;
    send_frame(20, 0, 260, 8'h55, 80);
    check(per_valid && per_data == 20, "R8", per_data, 20);
    send_frame(16, 0, 208, 8'h55, 64);
    check(per_valid && per_data == 20, "R8", per_data, 20);
    check(lock_cnt == l0 + 1 && abort_cnt == a0, "R8", abort_cnt - a0, 0);
    per_ready = 1'b1;
    @(negedge clk);
    check(per_valid == 1'b0, "R8", per_valid, 0);
  endtask

  initial begin
    per_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_nominal();
    t_skew();
    t_bad_byte();
    t_short_break();
    t_window();
    t_rearm();
    t_stop();
    t_timeout();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule